// File: doc/BRIEF.md
# Memory-Mapped Byte SPI Master

This block is a programmed-I/O SPI master attached to a simple 32-bit register bus. Software places one byte in the data register, then writes the control register with the start bit set. The block generates the serial clock from its own reference clock, shifts the byte out on MOSI while collecting a byte from MISO, and raises a busy flag until the eighth bit has been exchanged. Software polls that flag and then reads the received byte back from the data register.

The control register also holds three chip-select levels, a loopback enable and a 5-bit clock divider. The select lines are plain register bits driven straight to the pins, so software brackets a multi-byte exchange by lowering a select, running several single-byte transfers and raising it again. A control write that leaves the start bit clear only changes these settings. Speed and select can therefore be changed between bytes without causing a transfer.

Top module: `bytespi_master`

## Requirements
- R1: After reset the control register reads 0x00000015, all three select outputs are high, SCLK is low and the data register reads 0.
- R2: The control register is at byte address 0x0 and the data register at 0x4. A byte written to 0x4 is the next transmit byte. Reading 0x4 returns the last completed received byte in bits [7:0], with zeros above.
- R3: A control write with bit 1 set, made while idle, starts a transfer. Control bit 1 then reads 1 for exactly 16·(d+1) reference cycles after the write edge, and reads 0 afterwards.
- R4: A control write with bit 1 clear updates the select, loopback and divider fields and produces no SCLK pulse. Busy stays 0.
- R5: Select output n follows control bit 2n: bit 0 drives output 0, bit 2 drives output 1, bit 4 drives output 2. The written levels read back at the same positions.
- R6: Control bits [31:27] hold the divider d. SCLK has a period of 2·(d+1) reference cycles, and its last rising edge falls 15·(d+1) cycles after the start write.
- R7: The data is shifted MSB first in mode 0. SCLK idles low, MOSI changes only when SCLK falls, and MISO is captured when SCLK rises.
- R8: With control bit 3 set, the receive shifter takes the MOSI value instead of the MISO pin, so the received byte equals the transmitted byte whatever MISO carries.
- R9: Control and data writes made while busy is set are ignored. Select levels, divider, loopback and the stored transmit byte all keep their previous values.
- R10: A data-register read made during a transfer returns the byte from the previous completed transfer.
- R11: Each transfer produces exactly 8 SCLK pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on bus_rdata the next cycle |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | NUM_CS | Chip-select levels, straight from the control register |

## Verification
The hardest case to reach is a register access that lands in the middle of a byte. Such an access has to be ignored, or has to return the previous byte, and a program that always polls busy first never makes one. The bench therefore issues control and data writes and a data read right after a start command. It then checks that the selects do not move and that the divider reads back unchanged. It also checks that the transmit byte it overwrote is still the one echoed by a following loopback transfer. The busy window is measured by reading the control register on every cycle, which gives the exact count of 16·(d+1).

// File: rtl/bytespi_pkg.sv
package bytespi_pkg;
  localparam int BUS_W     = 32;
  localparam int START_POS = 1;   // start on write, busy on read
  localparam int LOOP_POS  = 3;
  localparam logic [7:0] CTRL_OFS = 8'h00;
  localparam logic [7:0] DATA_OFS = 8'h04;

  function automatic int sel_pos(input int n);
    return 2 * n;
  endfunction
endpackage

// File: rtl/bytespi_clkdiv.sv
module bytespi_clkdiv #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk) begin
    if (rst || !run_i) cnt_q <= '0;
    else if (cnt_q == div_i) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  // R6: the half-period counter never passes the divider value
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    run_i |-> cnt_q <= div_i);
endmodule

// File: rtl/bytespi_shift.sv
module bytespi_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] tx_i,
  input  logic              loop_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [BYTE_W-1:0] rx_o
);
  localparam int EDGES = 2 * BYTE_W;
  localparam int EC_W  = $clog2(EDGES);
  localparam logic [EC_W-1:0] LAST_EDGE = EC_W'(EDGES - 1);

  logic              busy_q, sclk_q, mosi_q;
  logic [BYTE_W-1:0] tx_sh, rx_sh, rx_q;
  logic [EC_W-1:0]   edge_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      rx_q   <= '0;
      edge_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        sclk_q <= 1'b0;
        mosi_q <= tx_i[BYTE_W-1];
        tx_sh  <= {tx_i[BYTE_W-2:0], 1'b0};
        edge_q <= '0;
      end
    end else if (tick_i) begin
      edge_q <= edge_q + 1'b1;
      if (!sclk_q) begin
        sclk_q <= 1'b1;
        rx_sh  <= {rx_sh[BYTE_W-2:0], loop_i ? mosi_q : miso_i};
      end else begin
        sclk_q <= 1'b0;
        if (edge_q == LAST_EDGE) begin
          busy_q <= 1'b0;
          rx_q   <= rx_sh;
        end else begin
          mosi_q <= tx_sh[BYTE_W-1];
          tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign sclk_o = sclk_q;
  assign mosi_o = mosi_q;
  assign rx_o   = rx_q;

  // R7: clock idles low
  a_r7_idle_low: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !sclk_q);
  // R7: within a byte MOSI moves only together with a falling SCLK
  a_r7_mosi_on_fall: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q) && !$stable(mosi_q)) |-> $fell(sclk_q));
  // R10: the visible received byte holds during a transfer
  a_r10_rx_hold: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> $stable(rx_q));
  // R4: busy rises only from a start request
  a_r4_no_spurious_busy: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !start_i) |=> !busy_q);
endmodule

// File: rtl/bytespi_regs.sv
module bytespi_regs
  import bytespi_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DIV_W  = 5,
  parameter int BYTE_W = 8,
  parameter int NUM_CS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] rx_i,
  output logic              start_o,
  output logic [NUM_CS-1:0] cs_o,
  output logic              loop_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [BYTE_W-1:0] tx_o
);
  localparam int DIV_LSB = BUS_W - DIV_W;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);

  logic              hit_ctrl, hit_data, wr_ok;
  logic [NUM_CS-1:0] cs_q;
  logic              loop_q;
  logic [DIV_W-1:0]  div_q;
  logic [BYTE_W-1:0] tx_q;
  logic [BUS_W-1:0]  rdata_q, ctrl_word;
  logic              unused_wdata;

  assign hit_ctrl = (addr_i == CTRL_A);
  assign hit_data = (addr_i == DATA_A);
  assign wr_ok    = wr_i && !busy_i;
  assign start_o  = wr_ok && hit_ctrl && wdata_i[START_POS];
  assign unused_wdata = ^wdata_i;

  always_comb begin
    ctrl_word = '0;
    for (int n = 0; n < NUM_CS; n++) ctrl_word[sel_pos(n)] = cs_q[n];
    ctrl_word[START_POS] = busy_i;
    ctrl_word[LOOP_POS]  = loop_q;
    ctrl_word[BUS_W-1:DIV_LSB] = div_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q    <= '1;
      loop_q  <= 1'b0;
      div_q   <= '0;
      tx_q    <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_ok && hit_ctrl) begin
        for (int n = 0; n < NUM_CS; n++) cs_q[n] <= wdata_i[sel_pos(n)];
        loop_q <= wdata_i[LOOP_POS];
        div_q  <= wdata_i[BUS_W-1:DIV_LSB];
      end
      if (wr_ok && hit_data) tx_q <= wdata_i[BYTE_W-1:0];
      if (rd_i) begin
        if (hit_ctrl)      rdata_q <= ctrl_word;
        else if (hit_data) rdata_q <= BUS_W'(rx_i);
        else               rdata_q <= '0;
      end
    end
  end

  assign rdata_o = rdata_q;
  assign cs_o    = cs_q;
  assign loop_o  = loop_q;
  assign div_o   = div_q;
  assign tx_o    = tx_q;

  // R9: settings are frozen while a byte is on the wire
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy_i && $past(busy_i)) |-> ($stable(cs_q) && $stable(div_q) && $stable(loop_q) && $stable(tx_q)));
endmodule

// File: rtl/bytespi_master.sv
module bytespi_master
  import bytespi_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DIV_W  = 5,
  parameter int BYTE_W = 8,
  parameter int NUM_CS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs
);
  logic              start, busy, loop_en, tick;
  logic [DIV_W-1:0]  div;
  logic [BYTE_W-1:0] tx_byte, rx_byte;

  bytespi_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .BYTE_W(BYTE_W), .NUM_CS(NUM_CS)) u_regs (
    .clk(clk), .rst(rst), .wr_i(bus_wr), .rd_i(bus_rd), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .rdata_o(bus_rdata), .busy_i(busy), .rx_i(rx_byte),
    .start_o(start), .cs_o(spi_cs), .loop_o(loop_en), .div_o(div), .tx_o(tx_byte)
  );

  bytespi_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run_i(busy), .div_i(div), .tick_o(tick)
  );

  bytespi_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst(rst), .start_i(start), .tx_i(tx_byte), .loop_i(loop_en),
    .tick_i(tick), .miso_i(spi_miso), .busy_o(busy), .sclk_o(spi_sclk),
    .mosi_o(spi_mosi), .rx_o(rx_byte)
  );

  // R3: an accepted start makes busy visible on the next cycle
  a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
endmodule

// File: tb/tb_bytespi_master.sv
module tb_bytespi_master;
  localparam int PERIOD = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        spi_sclk, spi_mosi, spi_miso;
  logic [2:0]  spi_cs;

  bytespi_master dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs)
  );

  always #(PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, rises = 0, falls = 0, last_rise = 0, period = 0, wr_cyc = 0, fall_base = 0;
  logic prev_sclk = 1'b0;
  logic [7:0] mosi_cap = '0, slv_byte = '0, prev_rx = '0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (spi_sclk && !prev_sclk) begin
      period = cyc - last_rise;
      last_rise = cyc;
      rises++;
    end
    prev_sclk = spi_sclk;
  end
  always @(posedge spi_sclk) mosi_cap = {mosi_cap[6:0], spi_mosi};
  always @(negedge spi_sclk) falls++;

  function automatic logic slave_bit(input int k, input logic [7:0] b);
    return (k >= 0 && k < 8) ? b[7-k] : 1'b0;
  endfunction
  assign spi_miso = slave_bit(falls - fall_base, slv_byte);

  function automatic logic [31:0] mk_ctrl(input logic [2:0] cs, input logic lp,
                                          input logic st, input logic [4:0] d);
    logic [31:0] w;
    w = '0;
    w[0] = cs[0]; w[2] = cs[1]; w[4] = cs[2];
    w[1] = st; w[3] = lp; w[31:27] = d;
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    wr_cyc = cyc;
    bus_wr = 0;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
    bus_rd = 0;
    @(negedge clk);
  endtask

  task automatic wait_idle(output int ones);
    logic [31:0] v;
    ones = 0;
    for (int i = 0; i < 4000; i++) begin
      bus_read(4'h0, v);
      if (!v[1]) break;
      ones++;
    end
  endtask

  task automatic xfer(input logic [4:0] d, input logic lp, input logic [2:0] cs,
                      input logic [7:0] tx, input logic [7:0] slv);
    int r0, ones, start_cyc;
    logic [31:0] v;
    logic [7:0] exp_rx;
    exp_rx = lp ? tx : slv;
    bus_write(4'h4, {24'h0, tx});
    slv_byte = slv; fall_base = falls; r0 = rises;
    bus_write(4'h0, mk_ctrl(cs, lp, 1'b1, d));
    start_cyc = wr_cyc;
    wait_idle(ones);
    chk("R3 busy cycles", ones, 16 * (d + 1));
    chk("R11 pulse count", rises - r0, 8);
    chk("R6 sclk period", period, 2 * (d + 1));
    chk("R6 last rise timing", last_rise - start_cyc, 15 * (d + 1));
    chk("R7 mosi msb first", {24'h0, mosi_cap}, {24'h0, tx});
    chk("R7 sclk idles low", {31'h0, spi_sclk}, 32'h0);
    bus_read(4'h4, v);
    chk(lp ? "R8 loopback echo" : "R2 received byte", v, {24'h0, exp_rx});
    bus_read(4'h0, v);
    chk("R6 control readback", v, mk_ctrl(cs, lp, 1'b0, d));
    prev_rx = exp_rx;
  endtask

  initial begin
    #(PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int r0, ones;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    bus_read(4'h0, v);
    chk("R1 control reset", v, 32'h15);
    chk("R1 select outputs", {29'h0, spi_cs}, 32'h7);
    chk("R1 sclk low", {31'h0, spi_sclk}, 32'h0);
    bus_read(4'h4, v);
    chk("R1 data reset", v, 32'h0);

    // R4, R5: every select pattern, no start bit
    for (int p = 0; p < 8; p++) begin
      r0 = rises;
      bus_write(4'h0, mk_ctrl(3'(p), p[0], 1'b0, 5'(p * 3)));
      repeat (4) @(negedge clk);
      chk("R5 select mapping", {29'h0, spi_cs}, 32'(p));
      bus_read(4'h0, v);
      chk("R4 settings only", v, mk_ctrl(3'(p), p[0], 1'b0, 5'(p * 3)));
      chk("R4 no pulses", rises - r0, 0);
    end

    // R6, R7, R2: plain transfers at several dividers
    xfer(5'd0, 1'b0, 3'b110, 8'hA5, 8'h3C);
    xfer(5'd3, 1'b0, 3'b101, 8'h81, 8'hE7);
    xfer(5'd1, 1'b0, 3'b011, 8'h00, 8'hFF);
    xfer(5'd31, 1'b0, 3'b111, 8'h6D, 8'h01);

    // R8: loopback ignores MISO (slave sends the complement)
    xfer(5'd0, 1'b1, 3'b110, 8'hA5, 8'h5A);
    xfer(5'd3, 1'b1, 3'b110, 8'hFF, 8'h00);
    xfer(5'd2, 1'b1, 3'b110, 8'h00, 8'hFF);
    xfer(5'd0, 1'b1, 3'b110, 8'h96, 8'h69);

    // R9, R10: accesses in the middle of a byte
    bus_write(4'h4, 32'h5A);
    slv_byte = 8'hC3; fall_base = falls; r0 = rises;
    bus_write(4'h0, mk_ctrl(3'b010, 1'b0, 1'b1, 5'd2));
    bus_write(4'h0, mk_ctrl(3'b101, 1'b1, 1'b1, 5'd0));
    bus_write(4'h4, 32'hFF);
    bus_read(4'h4, v);
    chk("R10 read during transfer", v, {24'h0, prev_rx});
    chk("R9 selects unchanged", {29'h0, spi_cs}, 32'h2);
    wait_idle(ones);
    chk("R9 single transfer", rises - r0, 8);
    bus_read(4'h4, v);
    chk("R9 received byte", v, 32'hC3);
    bus_read(4'h0, v);
    chk("R9 settings unchanged", v, mk_ctrl(3'b010, 1'b0, 1'b0, 5'd2));
    // R9: stored transmit byte survived the ignored data write
    bus_write(4'h0, mk_ctrl(3'b010, 1'b1, 1'b1, 5'd0));
    wait_idle(ones);
    bus_read(4'h4, v);
    chk("R9 transmit byte kept", v, 32'h5A);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule